// File: doc/BRIEF.md
# Raster Timing Meter

This block watches a video stream's horizontal sync, vertical sync and data-enable lines and works out the raster geometry. On the horizontal axis it counts, in pixel clocks, how long sync is asserted, the gap before data-enable rises, how long data-enable stays high, and the gap until the next sync. On the vertical axis it measures the same four intervals, counted in lines. Each interval is anchored on the asserting edge of its sync signal.

The results are held in a small register file on a simple single-cycle register bus. Writes take effect at the clock edge and reads are combinational. Pixel logic and bus logic share one clock. Software can choose the sync polarity for each axis. It can also choose whether horizontal results refresh on every line or only at frame boundaries. Each field that changes value sets a status bit, and those bits drive a maskable interrupt. A watchdog flags a lost horizontal sync after a programmable number of clocks without a sync edge.

Top module: `vid_timing_meter`

## Requirements
- R1: Horizontal fields are counted in clocks from the asserting edge of hsync. The sync field is the number of clocks hsync stays asserted. The back field runs from the sync trailing edge to data-enable rising. The active field is the number of clocks data-enable is high. The front field runs from data-enable falling to the next hsync asserting edge. A line updates the fields only if it contained data-enable. All intervals must be at least one clock.
- R2: Vertical fields are counted in lines, where a line starts at an hsync asserting edge. A line is a sync line when vsync is asserted at that edge, and an active line when data-enable was high anywhere in it. Vsync, back, active and front are counted as line runs in that order. A frame is published when the next sync line has ended.
- R3: Control bit 2 enables measurement and resets to 0. While it is clear, no measured register and no status bit changes, and the watchdog is held idle.
- R4: Control bit 0 (hsync) and control bit 1 (vsync) each mark their input as active-low. A set bit inverts that input before edge detection, so inverted stimulus yields identical measurements.
- R5: Status register 0x00 holds one bit per field: bits 0 to 3 are vsync, vback, vactive, vfront and bits 4 to 7 are hsync, hback, hactive, hfront. A bit sets when a newly published value differs from the held value. Writing 1 to a bit clears it, and a set in the same cycle wins.
- R6: The interrupt output is high exactly when control bit 3 is set and some status bit is set whose bit is also set in the mask register (0x28, same bit order, reset 0xFF).
- R7: With control bit 4 clear, horizontal results are published only at frame boundaries, meaning the end of the first sync line. With it set, they are published at the end of every measured line.
- R8: Register 0x2C holds the watchdog limit (reset 0x1FFF), and a write of zero is ignored. Status bit 0 at 0x30 is set while measurement is enabled and at least that many clocks have passed since the last hsync asserting edge.
- R9: Status bit 1 at 0x30 sets when the first complete frame is published after enable. It clears when measurement is disabled or when the watchdog fires.
- R10: Register layout on a 4-byte stride is: 0x00 status bits; 0x04..0x10 vsync, vback, vactive, vfront; 0x14..0x20 hsync, hback, hactive, hfront; 0x24 control (reset 0); 0x28 mask; 0x2C limit; 0x30 flags. Unused bits read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared pixel and bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_in | input | 1 | Horizontal sync |
| vsync_in | input | 1 | Vertical sync |
| de_in | input | 1 | Data enable |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume a synchronous reset and single-cycle bus writes. They also assume that a published value replaces the held value in the same cycle that it sets a status bit. They do not require well-formed video. The stimulus therefore builds whole lines and frames in which every interval is at least one clock or one line, vsync changes only at line starts, and data-enable stays inside the line. Parameter changes fall on frame starts, so every published value is either the old or the new timing. The deliberately broken sequences are a truncated frame, polarity switches and a sync outage. After each of them the stimulus runs settling frames and clears the status before it checks any values.

// File: rtl/vid_timing_meter.sv
module vid_timing_meter #(
  parameter int CNT_W = 16,
  parameter int TMO_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hsync_in,
  input  logic        vsync_in,
  input  logic        de_in,
  input  logic        bus_wr,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int NF = 8;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [TMO_W-1:0] TMO_MAX = '1;
  localparam logic [TMO_W-1:0] TMO_RST = TMO_W'(13'h1FFF);

  typedef enum logic [2:0] {P_IDLE, P_SYNC, P_BACK, P_ACT, P_FRONT} phase_t;

  logic [4:0] ctrl;
  logic [7:0] stat, mask;
  logic [TMO_W-1:0] tmo_val, wd;
  logic init_done, hs_q, vs_line, de_seen;
  logic [NF-1:0][CNT_W-1:0] held;
  logic [3:0][CNT_W-1:0] h_new;

  logic en, hs, vs, hs_rise, tmo;
  assign en      = ctrl[2];
  assign hs      = hsync_in ^ ctrl[0];
  assign vs      = vsync_in ^ ctrl[1];
  assign hs_rise = hs & ~hs_q;
  assign tmo     = en && (wd >= tmo_val);

  wire [1:0] syn = {hs, vs_line};
  wire [1:0] act = {de_in, de_seen};
  wire [1:0] stp = {1'b1, hs_rise};
  logic [1:0] done, start;
  logic [1:0][3:0][CNT_W-1:0] meas;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    phase_t ph;
    logic [CNT_W-1:0] cnt;
    logic [2:0][CNT_W-1:0] wv;
    logic sp, ap;
    wire sr = syn[a] & ~sp;
    wire sf = ~syn[a] & sp;
    wire ar = act[a] & ~ap;
    wire af = ~act[a] & ap;
    assign start[a] = en & stp[a] & sr;
    assign done[a]  = start[a] & (ph == P_FRONT);
    assign meas[a]  = {cnt, wv[2], wv[1], wv[0]};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ph <= P_IDLE; cnt <= '0; wv <= '0; sp <= 1'b0; ap <= 1'b0;
      end else begin
        if (stp[a]) begin
          sp <= syn[a];
          ap <= act[a];
        end
        if (!en) ph <= P_IDLE;
        else if (stp[a]) begin
          if (sr) begin
            ph <= P_SYNC; cnt <= CNT_W'(1);
          end else if (ph == P_SYNC && sf) begin
            wv[0] <= cnt; cnt <= CNT_W'(1); ph <= P_BACK;
          end else if (ph == P_BACK && ar) begin
            wv[1] <= cnt; cnt <= CNT_W'(1); ph <= P_ACT;
          end else if (ph == P_ACT && af) begin
            wv[2] <= cnt; cnt <= CNT_W'(1); ph <= P_FRONT;
          end else if (cnt != CNT_MAX) begin
            cnt <= cnt + CNT_W'(1);
          end
        end
      end
    end
  end

  wire frame_evt = start[0];
  wire h_pub = ctrl[4] ? done[1] : frame_evt;
  wire [3:0][CNT_W-1:0] h_src = done[1] ? meas[1] : h_new;
  wire [NF-1:0][CNT_W-1:0] pub_val = {h_src, meas[0]};
  wire [NF-1:0] pub_en = {{4{h_pub}}, {4{done[0]}}};
  logic [NF-1:0] chg;

  always_comb
    for (int k = 0; k < NF; k++) chg[k] = pub_en[k] && (pub_val[k] != held[k]);

  wire [7:0] clr = (bus_wr && bus_addr == 6'h00) ? bus_wdata[7:0] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; mask <= 8'hFF; tmo_val <= TMO_RST; stat <= '0;
      held <= '0; h_new <= '0; init_done <= 1'b0; wd <= '0;
      hs_q <= 1'b0; vs_line <= 1'b0; de_seen <= 1'b0;
    end else begin
      hs_q <= hs;
      if (hs_rise) begin
        vs_line <= vs;
        de_seen <= de_in;
      end else begin
        de_seen <= de_seen | de_in;
      end
      if (bus_wr) begin
        case (bus_addr)
          6'h24: ctrl <= bus_wdata[4:0];
          6'h28: mask <= bus_wdata[7:0];
          6'h2C: if (bus_wdata[TMO_W-1:0] != '0) tmo_val <= bus_wdata[TMO_W-1:0];
          default: ;
        endcase
      end
      stat <= (stat & ~clr) | chg;
      for (int k = 0; k < NF; k++)
        if (pub_en[k]) held[k] <= pub_val[k];
      if (done[1]) h_new <= meas[1];
      if (!en || tmo) init_done <= 1'b0;
      else if (done[0]) init_done <= 1'b1;
      if (!en || hs_rise) wd <= '0;
      else if (wd != TMO_MAX) wd <= wd + TMO_W'(1);
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      6'h00: bus_rdata[7:0] = stat;
      6'h04, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h18, 6'h1C, 6'h20:
        bus_rdata[CNT_W-1:0] = held[3'(bus_addr[5:2] - 4'd1)];
      6'h24: bus_rdata[4:0] = ctrl;
      6'h28: bus_rdata[7:0] = mask;
      6'h2C: bus_rdata[TMO_W-1:0] = tmo_val;
      6'h30: bus_rdata[1:0] = {init_done, tmo};
      default: ;
    endcase
  end

  assign irq = ctrl[3] & |(stat & mask);

  wire unused_wdata = ^bus_wdata[31:TMO_W];
endmodule

// File: rtl/vid_timing_meter_chk.sv
module vid_timing_meter_chk #(
  parameter int HW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          tmo,
  input logic          init_done,
  input logic          irq,
  input logic [7:0]    stat,
  input logic [7:0]    mask,
  input logic [HW-1:0] held
);
  a_r9_init_drops_on_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> !init_done);

  a_r9_init_drops_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !init_done);

  a_r3_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> $stable(held));

  a_r5_status_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat & ~$past(stat))) |-> (held != $past(held)));

  a_r6_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 8'h00) |-> !irq);

  a_r6_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat != 8'h00));
endmodule

bind vid_timing_meter vid_timing_meter_chk #(.HW(8*CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .tmo(tmo), .init_done(init_done),
  .irq(irq), .stat(stat), .mask(mask), .held(held)
);

// File: tb/test_vid_timing_meter.sv
module test_vid_timing_meter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hsync_in = 1'b0, vsync_in = 1'b0, de_in = 1'b0, bus_wr = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq;
  int total = 0, bad = 0;
  bit hp = 1'b0, vp = 1'b0;
  int cur[8], nxt[8];
  logic [31:0] rv;

  always #10 clk = ~clk;

  vid_timing_meter i_vid_timing_meter (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .de_in(de_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #2; d = bus_rdata;
  endtask

  task automatic line(input bit v, input bit d, input int p[8]);
    for (int i = 0; i < p[4] + p[5] + p[6] + p[7]; i++) begin
      @(negedge clk);
      hsync_in = (i < p[4]) ^ hp;
      vsync_in = v ^ vp;
      de_in = d && (i >= p[4] + p[5]) && (i < p[4] + p[5] + p[6]);
    end
  endtask

  task automatic frame(input int p[8]);
    for (int i = 0; i < p[0]; i++) line(1'b1, 1'b0, p);
    for (int i = 0; i < p[1]; i++) line(1'b0, 1'b0, p);
    for (int i = 0; i < p[2]; i++) line(1'b0, 1'b1, p);
    for (int i = 0; i < p[3]; i++) line(1'b0, 1'b0, p);
  endtask

  task automatic frames(input int n, input int p[8]);
    for (int i = 0; i < n; i++) frame(p);
  endtask

  task automatic pick(output int p[8]);
    p[0] = 1 + int'($urandom % 3);  p[1] = 1 + int'($urandom % 3);
    p[2] = 2 + int'($urandom % 5);  p[3] = 1 + int'($urandom % 3);
    p[4] = 1 + int'($urandom % 5);  p[5] = 1 + int'($urandom % 5);
    p[6] = 2 + int'($urandom % 10); p[7] = 1 + int'($urandom % 5);
  endtask

  function automatic logic [7:0] diff_bits(input int a[8], input int b[8]);
    logic [7:0] m = '0;
    for (int k = 0; k < 8; k++) m[k] = (a[k] != b[k]);
    return m;
  endfunction

  task automatic check_fields(input string tag, input int p[8]);
    logic [31:0] v;
    for (int k = 0; k < 8; k++) begin
      rd(6'(4 + 4 * k), v);
      check($sformatf("%s %s field %0d", tag, (k < 4) ? "R2" : "R1", k), v, 32'(p[k]));
    end
  endtask

  task automatic check_irq(input string tag, input logic exp);
    @(negedge clk); #2;
    check(tag, {31'd0, irq}, {31'd0, exp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all-reqs got=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed_set;
    logic [7:0] m, e;
    seed_set = $urandom(32'd4711);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    rd(6'h24, rv); check("R10 ctrl reset", rv, 32'h0);
    rd(6'h28, rv); check("R10 mask reset", rv, 32'hFF);
    rd(6'h2C, rv); check("R10 limit reset", rv, 32'h1FFF);
    rd(6'h30, rv); check("R10 flags reset", rv, 32'h0);
    rd(6'h00, rv); check("R10 status reset", rv, 32'h0);
    rd(6'h14, rv); check("R10 hsync field reset", rv, 32'h0);
    check_irq("R10 irq reset", 1'b0);

    wr(6'h24, 32'h4);
    pick(cur);
    frames(3, cur);
    check_fields("first", cur);
    rd(6'h00, rv); check("R5 all fields changed", rv, 32'hFF);
    rd(6'h30, rv); check("R9 init done", rv, 32'h2);
    check_irq("R6 irq off while disabled", 1'b0);

    wr(6'h00, 32'h0F);
    rd(6'h00, rv); check("R5 write one clears", rv, 32'hF0);
    wr(6'h24, 32'hC);
    wr(6'h28, 32'h00);
    check_irq("R6 all masked", 1'b0);
    wr(6'h28, 32'h10);
    check_irq("R6 unmasked hsync bit", 1'b1);
    wr(6'h00, 32'h10);
    check_irq("R6 cleared bit drops irq", 1'b0);
    wr(6'h00, 32'hFF);

    for (int it = 0; it < 6; it++) begin
      pick(nxt);
      e = diff_bits(cur, nxt);
      m = 8'($urandom);
      wr(6'h28, {24'd0, m});
      frames(3, nxt);
      cur = nxt;
      check_fields($sformatf("random %0d", it), cur);
      rd(6'h00, rv); check($sformatf("R5 change bits %0d", it), rv, {24'd0, e});
      check_irq($sformatf("R6 masked irq %0d", it), |(e & m));
      wr(6'h00, 32'hFF);
    end

    for (int u = 0; u < 2; u++) begin
      wr(6'h24, u ? 32'h14 : 32'h4);
      frames(2, cur);
      nxt = cur;
      nxt[4] = cur[4] + 1;
      for (int i = 0; i < cur[0]; i++) line(1'b1, 1'b0, nxt);
      for (int i = 0; i < cur[1]; i++) line(1'b0, 1'b0, nxt);
      for (int i = 0; i < cur[2]; i++) line(1'b0, 1'b1, nxt);
      line(1'b0, 1'b0, nxt);
      rd(6'h14, rv);
      check($sformatf("R7 mid-frame hsync mode %0d", u), rv, 32'(u ? nxt[4] : cur[4]));
      frames(3, cur);
      wr(6'h00, 32'hFF);
    end
    wr(6'h24, 32'h4);

    @(negedge clk); hp = 1'b1; vp = 1'b1; hsync_in = 1'b1; vsync_in = 1'b1;
    wr(6'h24, 32'h7);
    frames(3, cur);
    wr(6'h00, 32'hFF);
    frames(2, cur);
    check_fields("R4 inverted", cur);
    rd(6'h00, rv); check("R4 inverted steady status", rv, 32'h0);
    @(negedge clk); hp = 1'b0; vp = 1'b0; hsync_in = 1'b0; vsync_in = 1'b0;
    wr(6'h24, 32'h4);
    frames(3, cur);

    wr(6'h2C, 32'd64);
    frames(2, cur);
    rd(6'h30, rv); check("R8 no timeout on live sync", rv, 32'h2);
    repeat (100) @(negedge clk);
    rd(6'h30, rv); check("R8 R9 timeout flags", rv, 32'h1);
    wr(6'h2C, 32'd0);
    rd(6'h2C, rv); check("R8 zero limit ignored", rv, 32'd64);
    frames(3, cur);
    rd(6'h30, rv); check("R9 init returns", rv, 32'h2);
    wr(6'h2C, 32'h1FFF);

    wr(6'h00, 32'hFF);
    wr(6'h24, 32'h0);
    rd(6'h30, rv); check("R9 init cleared by disable", rv, 32'h0);
    for (int k = 0; k < 8; k++) nxt[k] = cur[k] + 1;
    frames(2, nxt);
    check_fields("R3 disabled hold", cur);
    rd(6'h00, rv); check("R3 no status while disabled", rv, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule